// File: doc/BRIEF.md
# SPI Serial-Memory Command Sequencer

This block sits on the host side of a SPI link to a serial nonvolatile memory. It turns one request into the complete chain of chip-select frames that the memory expects. A request carries an operation, a start address and a byte count. The block sends the opcode, the address bytes and any filler or dummy bytes itself. Write payload is taken from a valid/ready input stream, and read payload is delivered on a valid/ready output stream.

Operations that modify the memory or its status register are preceded automatically by a separate one-byte write-enable frame, with its own chip-select pulse. The address width follows the memory density given as a parameter. The serial clock comes from a divider of the system clock, and its idle level selects SPI mode 0 or mode 3. Either side of the data streams may stall. While a stream stalls, the block holds chip select low with the clock parked, so the memory sees one unbroken command.

Top module: `spi_mem_seq`

## Requirements
- R1: After reset the block shows csN high, sck at its idle level, busy low, reqReady high, wrReady low and rdValid low.
- R2: A status write (reqOp 0) and a memory write (reqOp 2) each begin with a frame that carries the single byte 0x06. Chip select is raised after that frame and lowered again before the next opcode.
- R3: A status write sends the frame [0x01, d], where d is the one byte taken from the write stream.
- R4: A status read (reqOp 1) sends the frame [0x05, 0x00]. The byte received during the 0x00 is delivered once on the read stream.
- R5: A memory write sends [0x02, address bytes, d1..dN]. The N payload bytes are taken from the write stream in arrival order.
- R6: A memory read (reqOp 3) sends [0x03, address bytes, then 0x00 once per byte] and delivers N bytes in order. A byte count of 0 is treated as 1.
- R7: A fast read (reqOp 4) sends [0x0B, address bytes, one 0x00 dummy, then 0x00 once per byte]. The byte clocked in during the dummy is not delivered.
- R8: Address bytes go most significant first. There are three of them when MEM_KBIT is 1024 or more, and two otherwise. Address bits at and above log2(MEM_KBIT)+7 are sent as 0.
- R9: Every byte is shifted MSb first. MOSI changes only while SCK is low, so the memory samples on the rising edge. While csN is high, SCK rests low when MODE3 is 0 and high when MODE3 is 1.
- R10: Each SCK high phase and each SCK low phase inside a byte lasts CLK_DIV system clocks.
- R11: If the write stream is empty or a delivered read byte is still waiting, the transfer pauses with csN held low and SCK idle. A waiting rdData stays stable until it is taken.
- R12: busy is high from the accepted request to completion. done pulses for exactly one cycle per request. reqReady is high only while the block is not busy, and csN is high whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqOp | input | 3 | 0 status write, 1 status read, 2 write, 3 read, 4 fast read |
| reqAddr | input | 24 | Start address |
| reqLen | input | LEN_W | Payload byte count for memory operations |
| wrData | input | 8 | Write payload byte |
| wrValid | input | 1 | Write payload byte offered |
| wrReady | output | 1 | Write payload byte taken when high with wrValid |
| rdData | output | 8 | Received payload byte |
| rdValid | output | 1 | Received byte waiting |
| rdReady | input | 1 | Consumer takes the received byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to memory |
| csN | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from memory |

## Verification
The bench targets the frame boundaries, because they are where a design is most likely to go wrong. A sequencer that leaves out the write-enable pulse, or merges it into the command frame, produces a write that the memory model refuses. Wrong address-byte counts, unmasked high address bits and a dummy byte passed through to the read stream all shift the recorded frame or the returned data by one byte. Long stalls on the write stream test whether chip select is dropped or clock edges leak while waiting. A mode-3 instance with a different divider and a two-byte address checks the idle level and the edge timing.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [2:0] {
    OP_STAT_WR = 3'd0,
    OP_STAT_RD = 3'd1,
    OP_MEM_WR  = 3'd2,
    OP_MEM_RD  = 3'd3,
    OP_FAST_RD = 3'd4
  } memOp_e;

  localparam logic [7:0] CMD_WEN  = 8'h06;
  localparam logic [7:0] CMD_SWR  = 8'h01;
  localparam logic [7:0] CMD_SRD  = 8'h05;
  localparam logic [7:0] CMD_WR   = 8'h02;
  localparam logic [7:0] CMD_RD   = 8'h03;
  localparam logic [7:0] CMD_FRD  = 8'h0B;
  localparam logic [7:0] FILL     = 8'h00;

  // strobes from the sequencer to the byte engine
  typedef struct packed {
    logic       csLow;
    logic       load;
    logic [7:0] txByte;
  } dpCtl_t;

endpackage

// File: rtl/spi_mem_dp.sv
module spi_mem_dp
  import spi_mem_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter bit SCK_IDLE = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       csN,
  output logic       tick,
  output logic       byteBusy,
  output logic       byteDone,
  output logic [7:0] rxByte
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic             active;
  logic             phaseHi;
  logic [2:0]       bitCnt;
  logic [7:0]       txSh;
  logic [7:0]       rxSh;

  assign tick     = (divCnt == DIV_LAST);
  assign sck      = active ? phaseHi : SCK_IDLE;
  assign mosi     = txSh[7];
  assign byteBusy = active;
  assign rxByte   = rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      active   <= 1'b0;
      phaseHi  <= 1'b0;
      bitCnt   <= '0;
      txSh     <= '0;
      rxSh     <= '0;
      csN      <= 1'b1;
      byteDone <= 1'b0;
    end else begin
      csN      <= !ctl.csLow;
      byteDone <= 1'b0;
      if (ctl.load && !active) begin
        txSh    <= ctl.txByte;
        active  <= 1'b1;
        bitCnt  <= '0;
        phaseHi <= 1'b0;
        divCnt  <= '0;
      end else begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (active && tick) begin
          if (!phaseHi) begin
            phaseHi <= 1'b1;
            rxSh    <= {rxSh[6:0], miso};
          end else begin
            phaseHi <= 1'b0;
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 3'd1;
              txSh   <= {txSh[6:0], 1'b0};
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int ADDR_BITS  = 17,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [2:0]       reqOp,
  input  logic [23:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic [7:0]       rdData,
  output logic             rdValid,
  input  logic             rdReady,
  output logic             busy,
  output logic             done,
  output dpCtl_t           ctl,
  input  logic             tick,
  input  logic             byteBusy,
  input  logic             byteDone,
  input  logic [7:0]       rxByte
);
  localparam int IDX_W = LEN_W + 2;
  localparam logic [23:0] ADDR_MASK = 24'((64'd1 << ADDR_BITS) - 64'd1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SEND, S_XFER, S_HOLD, S_GAP} state_e;

  state_e           state;
  memOp_e           op;
  logic [23:0]      addrQ;
  logic [LEN_W-1:0] dataCnt;
  logic [IDX_W-1:0] idx;
  logic             wrenPh;
  logic             csLow;

  logic [IDX_W-1:0] hdr;
  logic [IDX_W-1:0] lastIdx;
  logic             isRead;
  logic             isData;
  logic             needWr;
  logic             needRd;
  logic             canSend;
  logic [7:0]       txByte;

  always_comb begin
    case (op)
      OP_STAT_WR, OP_STAT_RD: hdr = IDX_W'(1);
      OP_FAST_RD:             hdr = IDX_W'(ADDR_BYTES + 2);
      default:                hdr = IDX_W'(ADDR_BYTES + 1);
    endcase
    isRead  = (op == OP_STAT_RD) || (op == OP_MEM_RD) || (op == OP_FAST_RD);
    isData  = idx >= hdr;
    lastIdx = wrenPh ? '0 : hdr + IDX_W'(dataCnt) - IDX_W'(1);
    needWr  = !wrenPh && isData && !isRead;
    needRd  = !wrenPh && isData && isRead;
    canSend = (state == S_SEND) && !byteBusy && (!needWr || wrValid) && (!needRd || !rdValid);
  end

  always_comb begin
    txByte = FILL;
    if (wrenPh) begin
      txByte = CMD_WEN;
    end else if (idx == '0) begin
      case (op)
        OP_STAT_WR: txByte = CMD_SWR;
        OP_STAT_RD: txByte = CMD_SRD;
        OP_MEM_WR:  txByte = CMD_WR;
        OP_FAST_RD: txByte = CMD_FRD;
        default:    txByte = CMD_RD;
      endcase
    end else if (isData) begin
      txByte = isRead ? FILL : wrData;
    end else begin
      for (int k = 1; k <= ADDR_BYTES; k++) begin
        if (idx == IDX_W'(k)) txByte = addrQ[8*(ADDR_BYTES-k) +: 8];
      end
    end
  end

  assign reqReady   = (state == S_IDLE);
  assign busy       = (state != S_IDLE);
  assign wrReady    = (state == S_SEND) && !byteBusy && needWr;
  assign ctl.csLow  = csLow;
  assign ctl.load   = canSend;
  assign ctl.txByte = txByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      op      <= OP_STAT_RD;
      addrQ   <= '0;
      dataCnt <= '0;
      idx     <= '0;
      wrenPh  <= 1'b0;
      csLow   <= 1'b0;
      rdValid <= 1'b0;
      rdData  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rdValid && rdReady) rdValid <= 1'b0;
      case (state)
        S_IDLE: if (reqValid) begin
          op      <= memOp_e'(reqOp);
          addrQ   <= reqAddr & ADDR_MASK;
          if (reqOp == OP_STAT_WR || reqOp == OP_STAT_RD || reqLen == '0) dataCnt <= LEN_W'(1);
          else dataCnt <= reqLen;
          wrenPh  <= (reqOp == OP_STAT_WR) || (reqOp == OP_MEM_WR);
          idx     <= '0;
          csLow   <= 1'b1;
          state   <= S_SETUP;
        end
        S_SETUP: if (tick) state <= S_SEND;
        S_SEND:  if (canSend) state <= S_XFER;
        S_XFER: if (byteDone) begin
          if (needRd) begin
            rdValid <= 1'b1;
            rdData  <= rxByte;
          end
          if (idx == lastIdx) state <= S_HOLD;
          else begin
            idx   <= idx + IDX_W'(1);
            state <= S_SEND;
          end
        end
        S_HOLD: if (tick) begin
          csLow <= 1'b0;
          state <= S_GAP;
        end
        S_GAP: if (tick) begin
          if (wrenPh) begin
            wrenPh <= 1'b0;
            idx    <= '0;
            csLow  <= 1'b1;
            state  <= S_SETUP;
          end else begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_mem_seq.sv
module spi_mem_seq
  import spi_mem_pkg::*;
#(
  parameter int CLK_DIV  = 2,
  parameter int MEM_KBIT = 1024,
  parameter int MODE3    = 0,
  parameter int LEN_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [2:0]       reqOp,
  input  logic [23:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic [7:0]       rdData,
  output logic             rdValid,
  input  logic             rdReady,
  output logic             busy,
  output logic             done,
  output logic             sck,
  output logic             mosi,
  output logic             csN,
  input  logic             miso
);
  localparam int ADDR_BYTES = (MEM_KBIT >= 1024) ? 3 : 2;
  localparam int ADDR_BITS  = $clog2(MEM_KBIT) + 7;

  dpCtl_t     ctl;
  logic       tick;
  logic       byteBusy;
  logic       byteDone;
  logic [7:0] rxByte;

  spi_mem_ctrl #(
    .ADDR_BYTES(ADDR_BYTES), .ADDR_BITS(ADDR_BITS), .LEN_W(LEN_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqLen(reqLen),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .busy(busy), .done(done), .ctl(ctl),
    .tick(tick), .byteBusy(byteBusy), .byteDone(byteDone), .rxByte(rxByte)
  );

  spi_mem_dp #(
    .CLK_DIV(CLK_DIV), .SCK_IDLE(MODE3 != 0)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .miso(miso),
    .sck(sck), .mosi(mosi), .csN(csN),
    .tick(tick), .byteBusy(byteBusy), .byteDone(byteDone), .rxByte(rxByte)
  );
endmodule

// File: rtl/spi_mem_seq_chk.sv
module spi_mem_seq_chk #(
  parameter int MODE3 = 0
) (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       reqReady,
  input logic       csN,
  input logic       sck,
  input logic       mosi,
  input logic       rdValid,
  input logic       rdReady,
  input logic [7:0] rdData,
  input logic       wrValid,
  input logic       wrReady
);
  localparam logic IDLE_LVL = (MODE3 != 0);

  p_cs_frame_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN) else $error("csN low while idle");

  p_sck_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (sck == IDLE_LVL)) else $error("sck not idle while deselected");

  p_mosi_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi)) else $error("mosi moved while sck high");

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle");

  p_req_ready_r12: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busy) else $error("reqReady while busy");

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData))) else $error("read byte dropped");

  p_wr_stall_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && wrReady && !wrValid) |=> !csN) else $error("frame broken during write stall");
endmodule

bind spi_mem_seq spi_mem_seq_chk #(.MODE3(MODE3)) uChk (.*);

// File: tb/spi_mem_seq_test.sv
module spi_mem_slave_model #(
  parameter int AB    = 3,
  parameter int ABITS = 17,
  parameter bit IDLE  = 1'b0
) (
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  byte unsigned mem [int];
  int          logQ[$];
  logic [7:0]  stReg = 8'h00;
  bit          wel = 1'b0;
  int          modeErr = 0;
  int          bitN = 0, idx = 0, addr = 0;
  logic [7:0]  inSh = 8'h00, txSh = 8'h00, op = 8'h00;
  int          mask = (1 << ABITS) - 1;

  initial miso = 1'b0;

  always @(negedge csN) begin
    bitN = 0; idx = 0; txSh = 8'h00;
    if (sck !== IDLE) modeErr++;
  end

  always @(posedge csN) begin
    logQ.push_back(-1);
    if (idx > 0) begin
      if (op == 8'h06 && idx == 1) wel = 1'b1;
      else if (op == 8'h02 || op == 8'h01) wel = 1'b0;
    end
    if (sck !== IDLE) modeErr++;
  end

  always @(posedge sck) if (csN === 1'b0) begin
    inSh = {inSh[6:0], mosi};
    bitN++;
    if (bitN == 8) begin
      bitN = 0;
      logQ.push_back(int'(inSh));
      if (idx == 0) begin op = inSh; addr = 0; end
      else if (op == 8'h01) begin if (idx == 1 && wel) stReg = inSh & 8'h8C; end
      else if (op == 8'h05) begin end
      else if (idx <= AB) addr = (addr << 8) | int'(inSh);
      else if (op == 8'h02 && wel) begin mem[addr & mask] = inSh; addr++; end
      idx++;
      txSh = 8'h00;
      if (op == 8'h05) txSh = stReg | {6'd0, wel, 1'b0};
      if ((op == 8'h03 && idx >= 1 + AB) || (op == 8'h0B && idx >= 2 + AB)) begin
        txSh = mem.exists(addr & mask) ? mem[addr & mask] : 8'h00;
        addr++;
      end
    end
  end

  always @(negedge sck) if (csN === 1'b0) begin
    miso = txSh[7];
    txSh = {txSh[6:0], 1'b0};
  end
endmodule

module spi_mem_seq_test;
  localparam int LW = 16;
  localparam int DIV0 = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic reqValid[2], reqReady[2], wrValid[2], wrReady[2], rdValid[2], rdReady[2];
  logic busy[2], done[2], sck[2], mosi[2], csN[2], miso[2];
  logic [2:0]    reqOp[2];
  logic [23:0]   reqAddr[2];
  logic [LW-1:0] reqLen[2];
  logic [7:0]    wrData[2], rdData[2];

  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  spi_mem_seq #(.CLK_DIV(DIV0), .MEM_KBIT(1024), .MODE3(0), .LEN_W(LW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[0]), .reqReady(reqReady[0]),
    .reqOp(reqOp[0]), .reqAddr(reqAddr[0]), .reqLen(reqLen[0]),
    .wrData(wrData[0]), .wrValid(wrValid[0]), .wrReady(wrReady[0]),
    .rdData(rdData[0]), .rdValid(rdValid[0]), .rdReady(rdReady[0]),
    .busy(busy[0]), .done(done[0]), .sck(sck[0]), .mosi(mosi[0]),
    .csN(csN[0]), .miso(miso[0]));

  spi_mem_seq #(.CLK_DIV(3), .MEM_KBIT(256), .MODE3(1), .LEN_W(LW)) uutB (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[1]), .reqReady(reqReady[1]),
    .reqOp(reqOp[1]), .reqAddr(reqAddr[1]), .reqLen(reqLen[1]),
    .wrData(wrData[1]), .wrValid(wrValid[1]), .wrReady(wrReady[1]),
    .rdData(rdData[1]), .rdValid(rdValid[1]), .rdReady(rdReady[1]),
    .busy(busy[1]), .done(done[1]), .sck(sck[1]), .mosi(mosi[1]),
    .csN(csN[1]), .miso(miso[1]));

  spi_mem_slave_model #(.AB(3), .ABITS(17), .IDLE(1'b0)) sm0 (
    .csN(csN[0]), .sck(sck[0]), .mosi(mosi[0]), .miso(miso[0]));
  spi_mem_slave_model #(.AB(2), .ABITS(15), .IDLE(1'b1)) sm1 (
    .csN(csN[1]), .sck(sck[1]), .mosi(mosi[1]), .miso(miso[1]));

  // per-clock reference of the serial idle level and the SCK high time
  int idleBad = 0, hiCnt = 0, hiBad = 0, nPulse = 0;
  always @(posedge clk) if (rstN) begin
    for (int u = 0; u < 2; u++)
      if (csN[u] === 1'b1 && sck[u] !== (u == 1)) idleBad++;
    if (sck[0] === 1'b1) hiCnt++;
    else begin
      if (hiCnt != 0) begin
        nPulse++;
        if (hiCnt != DIV0) hiBad++;
      end
      hiCnt = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmpLog(input int u, input int exp[$], input string tag);
    int got[$];
    int a, e;
    bit ok;
    if (u == 0) got = sm0.logQ; else got = sm1.logQ;
    ok = (got.size() == exp.size());
    a = got.size(); e = exp.size();
    for (int i = 0; i < got.size() && i < exp.size(); i++)
      if (ok && got[i] != exp[i]) begin ok = 1'b0; a = got[i]; e = exp[i]; end
    chk(ok, tag, a, e);
  endtask

  task automatic runOp(input int u, input int op, input int addr, input int len,
                       input int wq[$], input int stall,
                       output int rq[$], output bit handshakeOk, output bit stallOk);
    int wi = 0, it = 0, doneCnt = 0;
    bit wFire = 1'b0, reqFire = 1'b0, fin = 1'b0, busySeen = 1'b0;
    rq = {};
    stallOk = 1'b1;
    if (u == 0) sm0.logQ.delete(); else sm1.logQ.delete();
    @(negedge clk);
    reqValid[u] = 1'b1; reqOp[u] = 3'(op); reqAddr[u] = 24'(addr); reqLen[u] = LW'(len);
    while (!fin) begin
      reqFire = reqValid[u] && reqReady[u];
      wFire   = wrValid[u] && wrReady[u];
      if (rdValid[u] && rdReady[u]) rq.push_back(int'(rdData[u]));
      @(negedge clk);
      it++;
      if (reqFire) reqValid[u] = 1'b0;
      if (wFire) wi++;
      wrValid[u] = (wi < wq.size()) && (it >= stall) && ($urandom_range(3) != 0);
      wrData[u]  = (wi < wq.size()) ? 8'(wq[wi]) : 8'h00;
      rdReady[u] = ($urandom_range(2) != 0);
      if (busy[u]) busySeen = 1'b1;
      if (stall > 0 && it > stall - 20 && it < stall && (csN[u] !== 1'b0 || sck[u] !== (u == 1)))
        stallOk = 1'b0;
      if (done[u]) doneCnt++;
      if (doneCnt > 0 && !done[u] && !rdValid[u]) fin = 1'b1;
      if (it > 20000) fin = 1'b1;
    end
    wrValid[u] = 1'b0; rdReady[u] = 1'b1;
    handshakeOk = busySeen && (doneCnt == 1) && !busy[u] && reqReady[u];
  endtask

  task automatic cmpData(input int got[$], input int exp[$], input string tag);
    bit ok = (got.size() == exp.size());
    int a = got.size(), e = exp.size();
    for (int i = 0; i < got.size() && i < exp.size(); i++)
      if (ok && got[i] != exp[i]) begin ok = 1'b0; a = got[i]; e = exp[i]; end
    chk(ok, tag, a, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    int rq[$];
    bit hs, st;
    for (int u = 0; u < 2; u++) begin
      reqValid[u] = 0; reqOp[u] = 0; reqAddr[u] = 0; reqLen[u] = 0;
      wrData[u] = 0; wrValid[u] = 0; rdReady[u] = 1;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state, both instances (R9 idle level per mode)
    for (int u = 0; u < 2; u++)
      chk(csN[u] === 1'b1 && sck[u] === (u == 1) && busy[u] === 1'b0 && reqReady[u] === 1'b1
          && wrReady[u] === 1'b0 && rdValid[u] === 1'b0,
          "R1 reset outputs", {csN[u], sck[u], busy[u], reqReady[u]}, {1'b1, u == 1, 2'b01});
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 status write with write-enable prefix
    runOp(0, 0, 0, 0, '{8'h8C}, 0, rq, hs, st);
    cmpLog(0, '{6, -1, 1, 8'h8C, -1}, "R2 R3 status write frames");
    chk(hs, "R12 busy/done status write", hs, 1);

    // R4 status read
    runOp(0, 1, 0, 0, '{}, 0, rq, hs, st);
    cmpLog(0, '{5, 0, -1}, "R4 status read frame");
    cmpData(rq, '{8'h8C}, "R4 status read data");

    // R5 R8 burst write, three address bytes
    runOp(0, 2, 24'h012345, 5, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, 0, rq, hs, st);
    cmpLog(0, '{6, -1, 2, 8'h01, 8'h23, 8'h45, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, -1},
           "R5 R8 write frames");
    chk(hs, "R12 busy/done write", hs, 1);

    // R6 burst read
    runOp(0, 3, 24'h012345, 5, '{}, 0, rq, hs, st);
    cmpLog(0, '{3, 8'h01, 8'h23, 8'h45, 0, 0, 0, 0, 0, -1}, "R6 read frame");
    cmpData(rq, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, "R6 read data");

    // R7 fast read, dummy byte not delivered
    runOp(0, 4, 24'h012346, 3, '{}, 0, rq, hs, st);
    cmpLog(0, '{8'h0B, 8'h01, 8'h23, 8'h46, 0, 0, 0, 0, -1}, "R7 fast read frame");
    cmpData(rq, '{8'h22, 8'h33, 8'h44}, "R7 fast read data");

    // R6 zero count treated as one
    runOp(0, 3, 24'h012347, 0, '{}, 0, rq, hs, st);
    cmpLog(0, '{3, 8'h01, 8'h23, 8'h47, 0, -1}, "R6 zero count frame");
    cmpData(rq, '{8'h33}, "R6 zero count data");

    // R8 high address bits beyond 17 are sent as zero
    runOp(0, 3, 24'hFE2348, 1, '{}, 0, rq, hs, st);
    cmpLog(0, '{3, 8'h00, 8'h23, 8'h48, 0, -1}, "R8 masked address frame");

    // R11 long write-stream stall holds the frame
    runOp(0, 2, 24'h000100, 2, '{8'hA5, 8'h5A}, 400, rq, hs, st);
    chk(st, "R11 stall keeps csN low and sck idle", st, 1);
    cmpLog(0, '{6, -1, 2, 8'h00, 8'h01, 8'h00, 8'hA5, 8'h5A, -1}, "R11 stalled write frames");
    runOp(0, 3, 24'h000100, 2, '{}, 0, rq, hs, st);
    cmpData(rq, '{8'hA5, 8'h5A}, "R11 stalled write readback");

    // R8 R9 two-byte address, mode 3 instance
    runOp(1, 2, 24'h00FFFF, 2, '{8'hC3, 8'h3C}, 0, rq, hs, st);
    cmpLog(1, '{6, -1, 2, 8'h7F, 8'hFF, 8'hC3, 8'h3C, -1}, "R8 R9 mode3 write frames");
    chk(hs, "R12 busy/done mode3", hs, 1);
    runOp(1, 3, 24'h007FFF, 2, '{}, 0, rq, hs, st);
    cmpLog(1, '{3, 8'h7F, 8'hFF, 0, 0, -1}, "R9 mode3 read frame");
    cmpData(rq, '{8'hC3, 8'h3C}, "R9 mode3 read data");

    chk(sm0.modeErr == 0 && sm1.modeErr == 0 && idleBad == 0, "R9 idle level at frame edges",
        sm0.modeErr + sm1.modeErr + idleBad, 0);
    chk(hiBad == 0 && nPulse > 0, "R10 sck high phase length", hiBad, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule